// File: doc/BRIEF.md
# Configurable LUT Logic Row

This block is one row of a fine-grained reconfigurable array. It holds one bit-slice logic cell for each bit of a register word. Cell k sees bit k of every register in a bit-interleaved shadow copy of the register file, and it also sees the output lines that cell k of the row above drives. Each cell picks its four operands from that pool through its own configuration. It evaluates them as a single 4-input lookup table, as two 3-input tables that share three operands, or as a 3-input table feeding one stage of a carry chain that runs the length of the row. A row therefore does addition, subtraction and magnitude comparison in one pass.

The configuration image enters one bit per clock through a serial load port into a shadow image. A commit strobe copies the whole image into the active image in one step, so a row never runs on a half-loaded setting. Each cell routes its results, its inverted first result or a raw operand onto its output lines under per-line select fields. It can also drive either of two row-wide long lines, which OR the contributions of all cells. One configuration bit puts a register stage in front of the cell results.

Top module: `lut_logic_row`

## Requirements
- R1: After reset the active image is all zeros, so every cell output line, both long lines and the row carry-out read 0 whatever the register and upper-row inputs are.
- R2: While `cfg_load` is high, the value on `cfg_bit` shifts into the shadow image at each clock, and the first bit sent after `IMG` shifts lands at image index 0. The outputs follow the previous active image until a clock with `cfg_commit` high copies the shadow into the active image. Image bit 0 is the row carry-in and bit 1 is the register-stage enable. Cell k occupies `CB` bits from index 2+k*CB: table [15:0], mode [17:16], the selects of operands a, b, c, d at [18+i*SELW +: SELW], then one 3-bit select per output line, then one each for long lines A and B.
- R3: With mode 0 (or 3), both results F1 and F2 equal table bit {d,c,b,a}, with a as the least significant bit of the index.
- R4: With mode 1, F1 equals table bit {0,c,b,a} and F2 equals table bit {1,c,b,a}.
- R5: With mode 2, y is table bit {0,c,b,a}, F1 is a XOR y XOR carry-in and F2 is that cell's carry-out (a AND y) OR (carry-in AND (a XOR y)). With y = b in every cell the row adds the two words.
- R6: Image bit 0 is the carry into cell 0. With y = NOT b and that bit set, the row yields a minus b modulo 2^WIDTH, and the row carry-out is 1 exactly when a is at least b (unsigned).
- R7: A cell that is not in mode 2 passes its carry-in to its carry-out unchanged, so a row with no mode-2 cell returns image bit 0 as its carry-out.
- R8: Each operand select indexes the cell's own pool. Values 0..NREG-1 pick register bit k of that register, values NREG..NREG+NOUT-1 pick upper-row line value-NREG of column k, and larger values pick 0. Neighbouring cells choose independently.
- R9: Output select codes: 0 gives 0, 1 gives F1, 2 gives F2, 3 gives NOT F1, 4 to 7 give operands a, b, c, d.
- R10: Each long line is the OR of the values that the long-line selects of all cells pick, with the same code table. A line whose selects are all 0 reads 0.
- R11: When image bit 1 is set and the register stage is built, F1 and F2 (including the F1 inside code 3) are taken from flops that sample them each clock, which adds one cycle. Operand codes 4 to 7 and the carry chain stay combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Shift enable for the serial configuration port |
| cfg_bit | input | 1 | Serial configuration data, image bit 0 sent first |
| cfg_commit | input | 1 | Copies the shadow image into the active image |
| regs_i | input | WIDTH*NREG | Bit-interleaved register copy, bit k*NREG+r is bit k of register r |
| above_i | input | WIDTH*NOUT | Output lines of the row above, bit k*NOUT+j is line j of column k |
| cell_out_o | output | WIDTH*NOUT | Output lines of this row, bit k*NOUT+j is line j of cell k |
| long_o | output | 2 | Row-wide long lines A (bit 0) and B (bit 1) |
| carry_o | output | 1 | Carry out of the most significant cell |

## Verification
The carry chain is the sharpest corner. A full sweep of both operands through add and subtract catches a chain that starts from a fixed 0 instead of the image bit, which breaks every subtraction and the compare result. It also catches a wrong majority term, which breaks sums only when a carry ripples across several cells. A mixed row, with one table cell in the middle of an arithmetic chain, shows whether non-arithmetic cells pass the carry or kill it. Sweeps of the table and dual-table modes over all operand patterns show a swapped index order or swapped halves. A row that let the shadow image leak into the active image before commit would change its outputs during loading. A register stage in the wrong place would move pass-through operands by a cycle, or leave F1 unregistered.

// File: rtl/lrow_pkg.sv
package lrow_pkg;

   typedef enum logic [1:0] {
      MD_LUT4  = 2'd0,
      MD_DUAL3 = 2'd1,
      MD_ARITH = 2'd2,
      MD_LUT4X = 2'd3
   } cell_mode_e;

   typedef enum logic [2:0] {
      OS_ZERO = 3'd0,
      OS_F1   = 3'd1,
      OS_F2   = 3'd2,
      OS_NF1  = 3'd3,
      OS_A    = 3'd4,
      OS_B    = 3'd5,
      OS_C    = 3'd6,
      OS_D    = 3'd7
   } out_sel_e;

   localparam int LUT_BITS    = 16;
   localparam int MODE_BITS   = 2;
   localparam int N_OPND      = 4;
   localparam int OSEL_BITS   = 3;
   localparam int N_LONG      = 2;
   localparam int ROW_GLOBALS = 2;
   localparam int G_CIN       = 0;
   localparam int G_REGEN     = 1;

   function automatic int sel_width(input int pool);
      return (pool < 2) ? 1 : $clog2(pool);
   endfunction

   function automatic int cell_bits(input int selw, input int nout);
      return LUT_BITS + MODE_BITS + N_OPND * selw + (nout + N_LONG) * OSEL_BITS;
   endfunction

endpackage

// File: rtl/lrow_cfg_chain.sv
module lrow_cfg_chain #(
   parameter int IMG = 64
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           load_i,
   input  logic           bit_i,
   input  logic           commit_i,
   output logic [IMG-1:0] shadow_o,
   output logic [IMG-1:0] active_o
);

   logic [IMG-1:0] shd_q;
   logic [IMG-1:0] act_q;

   generate
      if (IMG == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      shd_q <= '0;
            else if (load_i) shd_q <= bit_i;
         end
      end else begin : g_many
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      shd_q <= '0;
            else if (load_i) shd_q <= {bit_i, shd_q[IMG-1:1]};
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        act_q <= '0;
      else if (commit_i) act_q <= shd_q;
   end

   assign shadow_o = shd_q;
   assign active_o = act_q;

endmodule

// File: rtl/lrow_route.sv
module lrow_route #(
   parameter int NLINE = 6
) (
   input  logic [NLINE*3-1:0] sel_i,
   input  logic               f1_i,
   input  logic               f2_i,
   input  logic [3:0]         opnd_i,
   output logic [NLINE-1:0]   line_o
);
   import lrow_pkg::*;

   genvar l;
   generate
      for (l = 0; l < NLINE; l++) begin : g_line
         out_sel_e code;
         assign code = out_sel_e'(sel_i[l*3 +: 3]);
         always_comb begin
            case (code)
               OS_ZERO: line_o[l] = 1'b0;
               OS_F1:   line_o[l] = f1_i;
               OS_F2:   line_o[l] = f2_i;
               OS_NF1:  line_o[l] = ~f1_i;
               OS_A:    line_o[l] = opnd_i[0];
               OS_B:    line_o[l] = opnd_i[1];
               OS_C:    line_o[l] = opnd_i[2];
               default: line_o[l] = opnd_i[3];
            endcase
         end
      end
   endgenerate

endmodule

// File: rtl/lrow_cell.sv
module lrow_cell #(
   parameter int NREG      = 8,
   parameter int NOUT      = 4,
   parameter bit REG_STAGE = 1'b1,
   localparam int POOL     = NREG + NOUT,
   localparam int SELW     = lrow_pkg::sel_width(POOL),
   localparam int CB       = lrow_pkg::cell_bits(SELW, NOUT)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [CB-1:0]   cfg_i,
   input  logic            reg_en_i,
   input  logic [NREG-1:0] regs_i,
   input  logic [NOUT-1:0] above_i,
   input  logic            cin_i,
   output logic            cout_o,
   output logic [NOUT-1:0] out_o,
   output logic [1:0]      long_o
);
   import lrow_pkg::*;

   localparam int PW     = 1 << SELW;
   localparam int O_MODE = LUT_BITS;
   localparam int O_SEL  = LUT_BITS + MODE_BITS;
   localparam int O_OUT  = O_SEL + N_OPND * SELW;
   localparam int NLINE  = NOUT + N_LONG;

   logic [PW-1:0] pool;
   logic [3:0]    opnd;
   logic [15:0]   lut;
   cell_mode_e    mode;
   logic          a, b, c, d;
   logic          lut4, lo3, hi3, gen;
   logic          f1, f2, f1_v, f2_v;

   always_comb begin
      pool = '0;
      pool[POOL-1:0] = {above_i, regs_i};
   end

   genvar i;
   generate
      for (i = 0; i < N_OPND; i++) begin : g_opnd
         logic [SELW-1:0] sel;
         assign sel     = cfg_i[O_SEL + i*SELW +: SELW];
         assign opnd[i] = pool[sel];
      end
   endgenerate

   assign lut  = cfg_i[LUT_BITS-1:0];
   assign mode = cell_mode_e'(cfg_i[O_MODE +: MODE_BITS]);
   assign {d, c, b, a} = opnd;

   assign lut4 = lut[{d, c, b, a}];
   assign lo3  = lut[{1'b0, c, b, a}];
   assign hi3  = lut[{1'b1, c, b, a}];
   assign gen  = (a & lo3) | (cin_i & (a ^ lo3));

   always_comb begin
      case (mode)
         MD_DUAL3: begin
            f1     = lo3;
            f2     = hi3;
            cout_o = cin_i;
         end
         MD_ARITH: begin
            f1     = a ^ lo3 ^ cin_i;
            f2     = gen;
            cout_o = gen;
         end
         default: begin
            f1     = lut4;
            f2     = lut4;
            cout_o = cin_i;
         end
      endcase
   end

   generate
      if (REG_STAGE) begin : g_reg
         logic f1_q, f2_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               f1_q <= 1'b0;
               f2_q <= 1'b0;
            end else begin
               f1_q <= f1;
               f2_q <= f2;
            end
         end
         assign f1_v = reg_en_i ? f1_q : f1;
         assign f2_v = reg_en_i ? f2_q : f2;
      end else begin : g_comb
         logic unused_regen;
         assign unused_regen = reg_en_i ^ clk ^ rst_n;
         assign f1_v = f1;
         assign f2_v = f2;
      end
   endgenerate

   logic [NLINE-1:0] lines;

   lrow_route #(.NLINE(NLINE)) u_route (
      .sel_i  (cfg_i[O_OUT +: NLINE*OSEL_BITS]),
      .f1_i   (f1_v),
      .f2_i   (f2_v),
      .opnd_i (opnd),
      .line_o (lines)
   );

   assign out_o  = lines[NOUT-1:0];
   assign long_o = lines[NLINE-1:NOUT];

endmodule

// File: rtl/lut_logic_row.sv
module lut_logic_row #(
   parameter int WIDTH     = 32,
   parameter int NREG      = 32,
   parameter int NOUT      = 4,
   parameter bit REG_STAGE = 1'b1,
   localparam int POOL     = NREG + NOUT,
   localparam int SELW     = lrow_pkg::sel_width(POOL),
   localparam int CB       = lrow_pkg::cell_bits(SELW, NOUT),
   localparam int IMG      = lrow_pkg::ROW_GLOBALS + WIDTH * CB
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cfg_load,
   input  logic                  cfg_bit,
   input  logic                  cfg_commit,
   input  logic [WIDTH*NREG-1:0] regs_i,
   input  logic [WIDTH*NOUT-1:0] above_i,
   output logic [WIDTH*NOUT-1:0] cell_out_o,
   output logic [1:0]            long_o,
   output logic                  carry_o
);
   import lrow_pkg::*;

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("lut_logic_row: WIDTH must be at least 1");
      end
      if (NREG < 1) begin : g_bad_nreg
         $error("lut_logic_row: NREG must be at least 1");
      end
      if (NOUT < 1) begin : g_bad_nout
         $error("lut_logic_row: NOUT must be at least 1");
      end
   endgenerate

   logic [IMG-1:0]     cfg_shd;
   logic [IMG-1:0]     cfg_act;
   logic [WIDTH:0]     carry;
   logic [WIDTH*2-1:0] long_drv;

   lrow_cfg_chain #(.IMG(IMG)) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (cfg_load),
      .bit_i    (cfg_bit),
      .commit_i (cfg_commit),
      .shadow_o (cfg_shd),
      .active_o (cfg_act)
   );

   assign carry[0] = cfg_act[G_CIN];

   genvar k;
   generate
      for (k = 0; k < WIDTH; k++) begin : g_cell
         lrow_cell #(
            .NREG      (NREG),
            .NOUT      (NOUT),
            .REG_STAGE (REG_STAGE)
         ) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .cfg_i    (cfg_act[ROW_GLOBALS + k*CB +: CB]),
            .reg_en_i (cfg_act[G_REGEN]),
            .regs_i   (regs_i[k*NREG +: NREG]),
            .above_i  (above_i[k*NOUT +: NOUT]),
            .cin_i    (carry[k]),
            .cout_o   (carry[k+1]),
            .out_o    (cell_out_o[k*NOUT +: NOUT]),
            .long_o   (long_drv[k*2 +: 2])
         );
      end
   endgenerate

   always_comb begin
      long_o = '0;
      for (int n = 0; n < WIDTH; n++) long_o = long_o | long_drv[n*2 +: 2];
   end

   assign carry_o = carry[WIDTH];

endmodule

// File: rtl/lrow_checker.sv
module lrow_checker #(
   parameter int WIDTH = 32,
   parameter int NREG  = 32,
   parameter int NOUT  = 4,
   parameter int IMG   = 64,
   parameter int CB    = 32
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  cfg_commit,
   input logic [IMG-1:0]        cfg_shd,
   input logic [IMG-1:0]        cfg_act,
   input logic [WIDTH*NOUT-1:0] cell_out_o,
   input logic [1:0]            long_o,
   input logic                  carry_o
);
   import lrow_pkg::*;

   localparam int SELW   = sel_width(NREG + NOUT);
   localparam int O_MODE = LUT_BITS;
   localparam int O_LONG = LUT_BITS + MODE_BITS + N_OPND * SELW + NOUT * OSEL_BITS;

   logic any_arith;
   logic long_off;

   always_comb begin
      any_arith = 1'b0;
      long_off  = 1'b1;
      for (int k = 0; k < WIDTH; k++) begin
         if (cfg_act[ROW_GLOBALS + k*CB + O_MODE +: 2] == 2'd2) any_arith = 1'b1;
         if (cfg_act[ROW_GLOBALS + k*CB + O_LONG +: 6] != '0)   long_off  = 1'b0;
      end
   end

   p_blank_image_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_act == '0) |-> (cell_out_o == '0 && long_o == 2'b00 && !carry_o));

   p_hold_until_commit_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_commit |=> $stable(cfg_act));

   p_commit_takes_shadow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_commit |=> (cfg_act == $past(cfg_shd)));

   p_carry_passes_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !any_arith |-> (carry_o == cfg_act[G_CIN]));

   p_long_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      long_off |-> (long_o == 2'b00));

endmodule

bind lut_logic_row lrow_checker #(
   .WIDTH (WIDTH),
   .NREG  (NREG),
   .NOUT  (NOUT),
   .IMG   (IMG),
   .CB    (CB)
) u_lrow_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_commit (cfg_commit),
   .cfg_shd    (cfg_shd),
   .cfg_act    (cfg_act),
   .cell_out_o (cell_out_o),
   .long_o     (long_o),
   .carry_o    (carry_o)
);

// File: tb/tb_lut_logic_row.sv
`timescale 1ns/1ps
module tb_lut_logic_row;

   localparam int W   = 4;
   localparam int NR  = 4;
   localparam int NO  = 4;
   localparam int CB  = 48;
   localparam int IMG = 2 + W * CB;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            cfg_load = 1'b0;
   logic            cfg_bit = 1'b0;
   logic            cfg_commit = 1'b0;
   logic [W*NR-1:0] regs_i = '0;
   logic [W*NO-1:0] above_i = '0;
   logic [W*NO-1:0] cell_out_o;
   logic [1:0]      long_o;
   logic            carry_o;

   int nvec = 0;
   int nbad = 0;

   always #10 clk = ~clk;

   lut_logic_row #(.WIDTH(W), .NREG(NR), .NOUT(NO), .REG_STAGE(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_bit(cfg_bit),
      .cfg_commit(cfg_commit), .regs_i(regs_i), .above_i(above_i),
      .cell_out_o(cell_out_o), .long_o(long_o), .carry_o(carry_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nvec++;
      if (act !== exp) begin
         nbad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [CB-1:0] mk(input logic [15:0] lut, input logic [1:0] mode,
                                        input logic [2:0] sa, input logic [2:0] sb,
                                        input logic [2:0] sc, input logic [2:0] sd,
                                        input logic [2:0] o0, input logic [2:0] o1,
                                        input logic [2:0] o2, input logic [2:0] o3,
                                        input logic [2:0] la, input logic [2:0] lb);
      return {lb, la, o3, o2, o1, o0, sd, sc, sb, sa, mode, lut};
   endfunction

   function automatic logic [IMG-1:0] row(input logic [CB-1:0] c0, input logic [CB-1:0] c1,
                                          input logic [CB-1:0] c2, input logic [CB-1:0] c3,
                                          input logic cin, input logic regen);
      return {c3, c2, c1, c0, regen, cin};
   endfunction

   function automatic logic [15:0] pack(input logic [3:0] r0, input logic [3:0] r1,
                                        input logic [3:0] r2, input logic [3:0] r3);
      logic [15:0] p;
      for (int k = 0; k < 4; k++) begin
         p[k*4]   = r0[k];
         p[k*4+1] = r1[k];
         p[k*4+2] = r2[k];
         p[k*4+3] = r3[k];
      end
      return p;
   endfunction

   task automatic load_img(input logic [IMG-1:0] img, input bit commit);
      for (int i = 0; i < IMG; i++) begin
         cfg_load = 1'b1;
         cfg_bit  = img[i];
         @(negedge clk);
      end
      cfg_load = 1'b0;
      cfg_bit  = 1'b0;
      if (commit) begin
         cfg_commit = 1'b1;
         @(negedge clk);
         cfg_commit = 1'b0;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      nbad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end

   initial begin
      logic [15:0] luts [4];
      logic [CB-1:0] cc [4];
      logic [15:0] ex;
      regs_i  = 16'hA5C3;
      above_i = 16'h3C5A;
      repeat (3) @(negedge clk);
      // R1: blank image after reset
      chk("R1 outputs", {16'h0, cell_out_o}, 32'h0);
      chk("R1 long/carry", {29'h0, long_o, carry_o}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      #2 chk("R1 after release", {13'h0, cell_out_o, long_o, carry_o}, 32'h0);

      // R3 / R9: 4-input table mode, full index sweep
      luts[0] = 16'h6996; luts[1] = 16'hE817; luts[2] = 16'h8001; luts[3] = 16'h1234;
      for (int k = 0; k < 4; k++)
         cc[k] = mk(luts[k], 2'd0, 3'd0, 3'd1, 3'd2, 3'd3, 3'd1, 3'd2, 3'd3, 3'd4, 3'd0, 3'd0);
      load_img(row(cc[0], cc[1], cc[2], cc[3], 1'b0, 1'b0), 1'b1);
      for (int v = 0; v < 65536; v += 5) begin
         regs_i  = 16'(v);
         above_i = 16'(v * 13);
         #2;
         for (int k = 0; k < 4; k++) begin
            logic f;
            f = luts[k][regs_i[k*4 +: 4]];
            ex[k*4 +: 4] = {regs_i[k*4], ~f, f, f};
         end
         chk("R3/R9 lut4 lines", {16'h0, cell_out_o}, {16'h0, ex});
         chk("R7 carry passes", {31'h0, carry_o}, 32'h0);
         @(negedge clk);
      end

      // R4 / R9: dual 3-input tables
      luts[0] = 16'hB71E; luts[1] = 16'h0FF0; luts[2] = 16'h5AC3; luts[3] = 16'h9669;
      for (int k = 0; k < 4; k++)
         cc[k] = mk(luts[k], 2'd1, 3'd0, 3'd1, 3'd2, 3'd3, 3'd1, 3'd2, 3'd6, 3'd7, 3'd0, 3'd0);
      load_img(row(cc[0], cc[1], cc[2], cc[3], 1'b1, 1'b0), 1'b1);
      for (int v = 0; v < 65536; v += 3) begin
         regs_i = 16'(v);
         #2;
         for (int k = 0; k < 4; k++) begin
            logic [2:0] ix;
            ix = regs_i[k*4 +: 3];
            ex[k*4 +: 4] = {regs_i[k*4+3], regs_i[k*4+2], luts[k][{1'b1, ix}], luts[k][{1'b0, ix}]};
         end
         chk("R4 dual3 lines", {16'h0, cell_out_o}, {16'h0, ex});
         chk("R7 carry passes cin=1", {31'h0, carry_o}, 32'h1);
         @(negedge clk);
      end

      // R5 add and R6 subtract/compare, all operand pairs
      for (int mode = 0; mode < 2; mode++) begin
         for (int k = 0; k < 4; k++)
            cc[k] = mk((mode == 0) ? 16'h00CC : 16'h0033, 2'd2, 3'd0, 3'd1, 3'd2, 3'd3,
                       3'd1, 3'd2, 3'd0, 3'd0, 3'd0, 3'd0);
         load_img(row(cc[0], cc[1], cc[2], cc[3], 1'(mode), 1'b0), 1'b1);
         for (int x = 0; x < 16; x++) begin
            for (int y = 0; y < 16; y++) begin
               int yy, s;
               yy = (mode == 0) ? y : 15 - y;
               regs_i = pack(4'(x), 4'(y), 4'(x ^ y), 4'(x + 3));
               #2;
               s = x + yy + mode;
               for (int k = 0; k < 4; k++) begin
                  int m;
                  m = (1 << (k + 1)) - 1;
                  ex[k*4 +: 4] = {2'b00, 1'(((x & m) + (yy & m) + mode) >> (k + 1)), 1'(s >> k)};
               end
               if (mode == 0) begin
                  chk("R5 add sum/carries", {16'h0, cell_out_o}, {16'h0, ex});
                  chk("R5 add carry_o", {31'h0, carry_o}, {31'h0, 1'(s >> 4)});
               end else begin
                  chk("R6 sub diff", {16'h0, cell_out_o}, {16'h0, ex});
                  chk("R6 compare carry_o", {31'h0, carry_o}, {31'h0, 1'(x >= y)});
               end
               @(negedge clk);
            end
         end
      end

      // R7: table cell in the middle of an arithmetic chain
      for (int ci = 0; ci < 2; ci++) begin
         cc[0] = mk(16'h00CC, 2'd2, 3'd0, 3'd1, 3'd2, 3'd3, 3'd1, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0);
         cc[1] = mk(16'h0000, 2'd0, 3'd0, 3'd1, 3'd2, 3'd3, 3'd1, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0);
         cc[2] = cc[0];
         cc[3] = cc[0];
         load_img(row(cc[0], cc[1], cc[2], cc[3], 1'(ci), 1'b0), 1'b1);
         for (int x = 0; x < 16; x++) begin
            for (int y = 0; y < 16; y++) begin
               int t0, hi;
               regs_i = pack(4'(x), 4'(y), 4'(y), 4'(x));
               #2;
               t0 = (x & 1) + (y & 1) + ci;
               hi = (x >> 2) + (y >> 2) + (t0 >> 1);
               ex = '0;
               ex[0]  = 1'(t0);
               ex[8]  = 1'(hi);
               ex[12] = 1'(hi >> 1);
               chk("R7 mixed chain sums", {16'h0, cell_out_o}, {16'h0, ex});
               chk("R7 mixed chain carry_o", {31'h0, carry_o}, {31'h0, 1'(hi >> 2)});
               @(negedge clk);
            end
         end
      end

      // R8: independent operand selection over registers and upper-row lines
      cc[0] = mk(16'hAAAA, 2'd0, 3'd1, 3'd0, 3'd0, 3'd0, 3'd1, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0);
      cc[1] = mk(16'hAAAA, 2'd0, 3'd4, 3'd0, 3'd0, 3'd0, 3'd1, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0);
      cc[2] = mk(16'hAAAA, 2'd0, 3'd7, 3'd0, 3'd0, 3'd0, 3'd1, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0);
      cc[3] = mk(16'hAAAA, 2'd0, 3'd2, 3'd0, 3'd0, 3'd0, 3'd1, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0);
      load_img(row(cc[0], cc[1], cc[2], cc[3], 1'b0, 1'b0), 1'b1);
      for (int v = 0; v < 512; v++) begin
         regs_i  = 16'(v * 321);
         above_i = 16'(v * 777 + 5);
         #2;
         ex = '0;
         ex[0]  = regs_i[0*4 + 1];
         ex[4]  = above_i[1*4 + 0];
         ex[8]  = above_i[2*4 + 3];
         ex[12] = regs_i[3*4 + 2];
         chk("R8 per-cell operand choice", {16'h0, cell_out_o}, {16'h0, ex});
         @(negedge clk);
      end

      // R10: long lines OR the cells that drive them
      for (int k = 0; k < 4; k++)
         cc[k] = mk(16'hAAAA, 2'd0, 3'd0, 3'd1, 3'd2, 3'd3, 3'd0, 3'd0, 3'd0, 3'd0,
                    (k == 0 || k == 2) ? 3'd1 : 3'd0, (k == 3) ? 3'd4 : 3'd0);
      load_img(row(cc[0], cc[1], cc[2], cc[3], 1'b0, 1'b0), 1'b1);
      for (int v = 0; v < 16; v++) begin
         regs_i = pack(4'(v), 4'hF, 4'hF, 4'hF);
         #2;
         chk("R10 long lines", {30'h0, long_o}, {30'h0, 1'(v >> 3), 1'(v & 1) | 1'(v >> 2)});
         chk("R10 idle cell lines", {16'h0, cell_out_o}, 32'h0);
         @(negedge clk);
      end

      // R11: register stage delays F1/F2 by one cycle, operands stay direct
      for (int k = 0; k < 4; k++)
         cc[k] = mk(16'hAAAA, 2'd0, 3'd0, 3'd1, 3'd2, 3'd3, 3'd1, 3'd2, 3'd4, 3'd3, 3'd0, 3'd0);
      regs_i = '0;
      load_img(row(cc[0], cc[1], cc[2], cc[3], 1'b0, 1'b1), 1'b1);
      begin
         logic [3:0] prev;
         prev = 4'h0;
         for (int v = 1; v < 17; v++) begin
            logic [3:0] cur;
            cur = 4'(v * 7);
            regs_i = pack(cur, 4'h0, 4'h0, 4'h0);
            #2;
            for (int k = 0; k < 4; k++) ex[k*4 +: 4] = {~prev[k], cur[k], prev[k], prev[k]};
            chk("R11 registered F1/F2", {16'h0, cell_out_o}, {16'h0, ex});
            prev = cur;
            @(negedge clk);
         end
      end

      // R2: loading without commit leaves the row unchanged
      for (int k = 0; k < 4; k++)
         cc[k] = mk(16'hAAAA, 2'd0, 3'd0, 3'd1, 3'd2, 3'd3, 3'd1, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0);
      load_img(row(cc[0], cc[1], cc[2], cc[3], 1'b0, 1'b0), 1'b1);
      regs_i = pack(4'b1010, 4'h0, 4'h0, 4'h0);
      #2 chk("R2 committed image", {16'h0, cell_out_o}, 32'h1010);
      for (int k = 0; k < 4; k++)
         cc[k] = mk(16'h5555, 2'd0, 3'd0, 3'd1, 3'd2, 3'd3, 3'd1, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0);
      @(negedge clk);
      load_img(row(cc[0], cc[1], cc[2], cc[3], 1'b1, 1'b0), 1'b0);
      #2 chk("R2 no commit keeps lines", {16'h0, cell_out_o}, 32'h1010);
      chk("R2 no commit keeps carry", {31'h0, carry_o}, 32'h0);
      @(negedge clk);
      cfg_commit = 1'b1;
      @(negedge clk);
      cfg_commit = 1'b0;
      #2 chk("R2 commit applies lines", {16'h0, cell_out_o}, 32'h0101);
      chk("R2 commit applies carry", {31'h0, carry_o}, 32'h1);

      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end

endmodule